// File: doc/BRIEF.md
# Interrupt Level Recognition Unit

This block decides which external interrupt a processor core should take next. Seven active-low request lines come in from the board. Each line is brought into the core clock domain through a multi-flop synchroniser. The lines are numbered 1 to 7, and a higher number means higher priority. A 3-bit interrupt mask is held as the mask field of the core's status register. A request at levels 1 to 6 is eligible only while its line is low and its number is strictly greater than the mask. The unit presents the highest eligible level to the core as a request flag with a 3-bit level code.

The core answers with two single-cycle strobes. An acknowledge strobe accepts the presented level, and the mask takes that level. A status-write strobe loads a new mask value. This covers both explicit writes and the restore done on return from exception.

Level 7 cannot be masked and does not simply follow its line. A recognition latch is set by a falling edge on the synchronised line. It is cleared by a rising edge, by acceptance of the level 7 request, or by any status write. A status write also re-arms the edge detector. A level 7 line that is still low after the write therefore raises a fresh request on the following cycle, with no transition on the pin.

Top module: `irq_level_unit`

## Requirements
- R1: After reset the mask reads 7, the request flag is 0 and the level code is 0.
- R2: Each request line passes through two synchroniser flops. A level 1 to 6 change driven before a clock edge shows at the outputs after the second edge, and not after the first.
- R3: A low line at level L (1 to 6) raises a request only while the mask value is strictly less than L.
- R4: When several levels are eligible, the request presents the highest one as the binary level number (1 to 7). With no eligible level, the flag is 0 and the code is 0.
- R5: An acknowledge strobe while the request flag is high loads the mask with the presented level. Lines at that level and below then stop requesting.
- R6: A status write loads the mask from the write-data input. A level 1 to 6 line still low and above the new mask requests again immediately after that edge.
- R7: A falling edge on the level 7 line raises a level 7 request whatever the mask. The request appears one cycle after the synchronised edge, which is three edges after the pin change.
- R8: Acknowledging level 7 consumes the recognition latch. A line kept low afterwards raises no further request without a new edge or a status write.
- R9: A rising edge on the level 7 line clears a pending, unacknowledged level 7 request.
- R10: A new falling edge on the level 7 line during level 7 service (mask 7) raises a new level 7 request.
- R11: A status write clears the level 7 latch. If the line is still low, a new level 7 request appears one cycle after the write. If the line is high, none appears.
- R12: An acknowledge strobe while the request flag is 0 leaves the mask unchanged.
- R13: If a status write and an acknowledge arrive in the same cycle, the mask takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqLinesN | input | 7 | Active-low request lines; bit 0 is level 1, bit 6 is level 7 |
| ackStb | input | 1 | One-cycle acknowledge of the presented request |
| srWrStb | input | 1 | One-cycle status-register write, including restore on return from exception |
| srWrMask | input | 3 | Mask value carried by the status write |
| intReq | output | 1 | Interrupt request to the core |
| intLevel | output | 3 | Level of the presented request, 0 when none |
| maskOut | output | 3 | Current interrupt mask |

## Verification
The hardest situation to reach is the level 7 re-trigger after return from exception. It appears without any pin transition and one cycle later than a plain level 1 to 6 re-request. The bench reaches it in steps. It drives a falling edge on line 7, acknowledges it, and holds the line low while confirming that no new request arrives. It then issues a status write and samples the request flag twice: immediately after the write edge, when the flag must still be low, and one edge later, when it must be high. The same sequence is repeated with the line released to show that the write alone raises nothing.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes issued by the control section to the datapath each cycle.
  typedef struct packed {
    logic takeAck;     // accepted acknowledge: load mask from presented level
    logic writeSr;     // status write: load mask, clear and re-arm level-top latch
    logic consumeNmi;  // accepted acknowledge at the top (unmaskable) level
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH     = 7,
  parameter int STAGES    = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= {WIDTH{RST_VAL}};
          else       stageQ[s] <= asyncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= {WIDTH{RST_VAL}};
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_LEVELS  = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqLinesN,
  input  ctrlStrobes_t          strobes,
  input  logic [LVL_W-1:0]      srWrMask,
  input  logic [LVL_W-1:0]      ackLevel,
  output logic [NUM_LEVELS-1:0] pendVec,
  output logic [LVL_W-1:0]      maskQ
);

  localparam int TOP = NUM_LEVELS - 1;

  logic [NUM_LEVELS-1:0] syncN;
  logic                  topPrevQ;   // last seen value of the top line (1 = high)
  logic                  nmiPendQ;   // top-level recognition latch
  logic                  topFall;
  logic                  topRise;

  irq_sync #(
    .WIDTH  (NUM_LEVELS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(reqLinesN),
    .syncOut(syncN)
  );

  // Mask register: status write has priority over acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 maskQ <= LVL_W'(NUM_LEVELS);
    else if (strobes.writeSr)  maskQ <= srWrMask;
    else if (strobes.takeAck)  maskQ <= ackLevel;
  end

  assign topFall = topPrevQ && !syncN[TOP];
  assign topRise = !topPrevQ && syncN[TOP];

  // Edge reference: a status write re-arms it as if the line were high,
  // so a line still low is seen as a fresh falling edge next cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                topPrevQ <= 1'b1;
    else if (strobes.writeSr) topPrevQ <= 1'b1;
    else                      topPrevQ <= syncN[TOP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   nmiPendQ <= 1'b0;
    else if (strobes.writeSr)    nmiPendQ <= 1'b0;
    else if (topFall)            nmiPendQ <= 1'b1;
    else if (topRise)            nmiPendQ <= 1'b0;
    else if (strobes.consumeNmi) nmiPendQ <= 1'b0;
  end

  // Lower levels are plain level-sensitive; top level comes from the latch.
  always_comb begin
    pendVec      = ~syncN;
    pendVec[TOP] = nmiPendQ;
  end

  assert_mask_reset_R1: assert property (@(posedge clk)
    $rose(rstN) |-> maskQ == LVL_W'(NUM_LEVELS));

  assert_mask_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeAck && !strobes.writeSr |=> maskQ == $past(ackLevel));

  // R6 and R13: a write always lands, even alongside an acknowledge.
  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeSr |=> maskQ == $past(srWrMask));

  assert_mask_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeAck && !strobes.writeSr |=> $stable(maskQ));

  assert_nmi_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    topFall && !strobes.writeSr |=> nmiPendQ);

  assert_nmi_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    topRise |=> !nmiPendQ);

  assert_nmi_write_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeSr |=> !nmiPendQ);

  assert_nmi_consume_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.consumeNmi && !topFall |=> !nmiPendQ);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] pendVec,
  input  logic [LVL_W-1:0]      maskQ,
  input  logic                  ackStb,
  input  logic                  srWrStb,
  output logic                  intReq,
  output logic [LVL_W-1:0]      intLevel,
  output ctrlStrobes_t          strobes
);

  localparam int TOP = NUM_LEVELS - 1;

  logic [NUM_LEVELS-1:0] eligible;

  // Top level ignores the mask; the others need mask < level number.
  always_comb begin
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (i == TOP) eligible[i] = pendVec[i];
      else          eligible[i] = pendVec[i] && (maskQ < LVL_W'(i + 1));
    end
  end

  // Ascending scan: the last hit is the highest eligible level.
  always_comb begin
    intLevel = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (eligible[i]) intLevel = LVL_W'(i + 1);
    end
  end

  assign intReq = |eligible;

  always_comb begin
    strobes.takeAck    = ackStb && intReq;
    strobes.writeSr    = srWrStb;
    strobes.consumeNmi = ackStb && intReq && (intLevel == LVL_W'(NUM_LEVELS));
  end

  assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intLevel != '0);

  assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> intLevel == '0);

  assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    intReq && intLevel != LVL_W'(NUM_LEVELS) |-> intLevel > maskQ);

  assert_pending_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> pendVec[intLevel - 1'b1]);

endmodule

// File: rtl/irq_level_unit.sv
module irq_level_unit
  import irq_pkg::*;
#(
  parameter int NUM_LEVELS  = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqLinesN,
  input  logic                  ackStb,
  input  logic                  srWrStb,
  input  logic [LVL_W-1:0]      srWrMask,
  output logic                  intReq,
  output logic [LVL_W-1:0]      intLevel,
  output logic [LVL_W-1:0]      maskOut
);

  ctrlStrobes_t          strobes;
  logic [NUM_LEVELS-1:0] pendVec;
  logic [LVL_W-1:0]      maskQ;

  irq_datapath #(
    .NUM_LEVELS (NUM_LEVELS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqLinesN(reqLinesN),
    .strobes  (strobes),
    .srWrMask (srWrMask),
    .ackLevel (intLevel),
    .pendVec  (pendVec),
    .maskQ    (maskQ)
  );

  irq_ctrl #(
    .NUM_LEVELS(NUM_LEVELS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pendVec (pendVec),
    .maskQ   (maskQ),
    .ackStb  (ackStb),
    .srWrStb (srWrStb),
    .intReq  (intReq),
    .intLevel(intLevel),
    .strobes (strobes)
  );

  assign maskOut = maskQ;

endmodule

// File: tb/irq_level_unit_test.sv
module irq_level_unit_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] reqLinesN = 7'h7F;
  logic       ackStb = 1'b0;
  logic       srWrStb = 1'b0;
  logic [2:0] srWrMask = 3'd0;
  logic       intReq;
  logic [2:0] intLevel;
  logic [2:0] maskOut;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_level_unit uut (
    .clk      (clk),
    .rstN     (rstN),
    .reqLinesN(reqLinesN),
    .ackStb   (ackStb),
    .srWrStb  (srWrStb),
    .srWrMask (srWrMask),
    .intReq   (intReq),
    .intLevel (intLevel),
    .maskOut  (maskOut)
  );

  // Advance n rising edges, then settle 2 time units past the edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseAck();
    ackStb = 1'b1;
    tick(1);
    ackStb = 1'b0;
  endtask

  task automatic pulseWr(input logic [2:0] m);
    srWrStb  = 1'b1;
    srWrMask = m;
    tick(1);
    srWrStb  = 1'b0;
  endtask

  task automatic setLine(input int level, input logic lowActive);
    reqLinesN[level-1] = ~lowActive;
  endtask

  task automatic testReset();
    check("R1 mask", maskOut, 7);
    check("R1 req", intReq, 0);
    check("R1 level", intLevel, 0);
  endtask

  task automatic testSyncDelay();
    pulseWr(3'd0);
    setLine(5, 1'b1);
    tick(1);
    check("R2 after one edge", intReq, 0);
    tick(1);
    check("R2 after two edges", intReq, 1);
    check("R2 level", intLevel, 5);
    setLine(5, 1'b0);
    tick(2);
    check("R4 idle code", intLevel, 0);
  endtask

  task automatic testMaskAndPriority();
    pulseWr(3'd3);
    setLine(3, 1'b1);
    tick(2);
    check("R3 equal to mask blocked", intReq, 0);
    setLine(2, 1'b1);
    setLine(4, 1'b1);
    tick(2);
    check("R3 above mask req", intReq, 1);
    check("R4 highest wins", intLevel, 4);
    pulseAck();
    check("R5 mask from ack", maskOut, 4);
    check("R5 request drops", intReq, 0);
    setLine(6, 1'b1);
    tick(2);
    check("R4 higher arrives", intLevel, 6);
    pulseWr(3'd3);
    check("R6 mask written", maskOut, 3);
    check("R6 immediate re-request", intLevel, 6);
    setLine(6, 1'b0);
    tick(2);
    check("R6 remaining grounded line", intLevel, 4);
    setLine(2, 1'b0);
    setLine(3, 1'b0);
    setLine(4, 1'b0);
    tick(2);
    check("R4 all released", intReq, 0);
  endtask

  task automatic testTopLevel();
    pulseWr(3'd7);
    setLine(7, 1'b1);
    tick(2);
    check("R7 not before latch", intReq, 0);
    tick(1);
    check("R7 edge req", intReq, 1);
    check("R7 level", intLevel, 7);
    pulseAck();
    check("R8 mask 7", maskOut, 7);
    check("R8 consumed", intReq, 0);
    tick(5);
    check("R8 held low no re-req", intReq, 0);
    setLine(7, 1'b0);
    tick(3);
    setLine(7, 1'b1);
    tick(3);
    check("R10 new edge in service", intLevel, 7);
    pulseAck();
    check("R10 ack consumes", intReq, 0);
    pulseWr(3'd7);
    check("R11 not on write edge", intReq, 0);
    tick(1);
    check("R11 re-trigger after write", intReq, 1);
    check("R11 level", intLevel, 7);
    pulseAck();
    setLine(7, 1'b0);
    tick(3);
    pulseWr(3'd7);
    tick(2);
    check("R11 write with line high", intReq, 0);
  endtask

  task automatic testRiseClears();
    setLine(7, 1'b1);
    tick(3);
    check("R9 pending before rise", intReq, 1);
    setLine(7, 1'b0);
    tick(3);
    check("R9 rise clears", intReq, 0);
  endtask

  task automatic testAckCorners();
    pulseWr(3'd5);
    pulseAck();
    check("R12 idle ack ignored", maskOut, 5);
    pulseWr(3'd0);
    setLine(6, 1'b1);
    tick(2);
    check("R13 req present", intLevel, 6);
    ackStb   = 1'b1;
    srWrStb  = 1'b1;
    srWrMask = 3'd2;
    tick(1);
    ackStb  = 1'b0;
    srWrStb = 1'b0;
    check("R13 write wins", maskOut, 2);
    setLine(6, 1'b0);
    tick(2);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testSyncDelay();
    testMaskAndPriority();
    testTopLevel();
    testRiseClears();
    testAckCorners();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule